// File: doc/BRIEF.md
# Pseudo-Random Light Modulator

This block drives a single light output at low frequency, for example from a 32 kHz clock. An 8-bit maximal-length shift register steps once per clock and visits every nonzero value exactly once in each 255-cycle sequence. Each cycle, the current register value is compared with a programmed 8-bit brightness level. The output is registered high when the register value is strictly below the level. The on-cycles are therefore spread pseudo-randomly across the sequence instead of being grouped into one pulse.

Because the register never holds zero, the average on-time is max(level − 1, 0)/255. The duty steps in units of 1/255 from fully dark up to 254/255, so the top level is never continuously on. An enable input forces the output dark. The shift register keeps stepping while the output is dark, so the pattern stays locked to the time since reset.

Top module: `lpwm_light`

## Requirements
- R1: While reset is asserted the output is low. The shift register restarts from seed value 1, so with level 2 and enable high the first output after reset release is high and the second is low.
- R2: The shift register never holds zero. If it is ever found at zero it is reloaded with the seed on the next clock.
- R3: With a constant level and enable held high, the output sequence repeats exactly every 255 clocks.
- R4: Over any 255 consecutive clocks with constant level L and enable high, the output is high for exactly max(L − 1, 0) clocks.
- R5: Levels 0 and 1 keep the output continuously low.
- R6: Level 2 gives exactly one high clock in every 255.
- R7: Level 255 gives 254 high clocks in every 255, with at least one low clock in each sequence.
- R8: While enable is low the output is low from the clock after enable is sampled low. The output updates one clock after the inputs are sampled.
- R9: Holding enable low does not pause the shift register. After re-enabling, the output at each clock equals the output seen at the same position, counted in clocks since reset modulo 255, in an earlier enabled sequence with the same level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock (low-frequency) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; low forces the output dark |
| level | input | 8 | Brightness level, 0 to 255 |
| light_out | output | 1 | Registered light drive |

## Verification
Directed levels 0, 1, 2 and 255 separate the dark floor, the single-pulse step and the "never fully on" ceiling from each other. Seeded random levels in between count high clocks over a full sequence, which exposes an off-by-one in the comparison such as less-or-equal. A two-sequence capture at one level shows the 255-clock period, which a wrong tap set or a short cycle would break. A disable gap of odd length, followed by replay against a recorded pattern indexed by clocks since reset, tells a free-running register apart from one that stalls or restarts while the output is dark.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
    localparam int LVL_W = 8;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t state;
    } seq_reg_t;

    typedef struct packed {
        logic drive;
    } drv_reg_t;

    // Fibonacci feedback bit: parity of the tapped bits
    function automatic logic seq_feedback(input lvl_t s, input lvl_t taps);
        return ^(s & taps);
    endfunction
endpackage

// File: rtl/lpwm_seq.sv
module lpwm_seq
    import lpwm_pkg::*;
#(
    parameter lvl_t TAP_MASK = 8'b1011_1000,
    parameter lvl_t SEED     = 8'd1
) (
    input  logic clk,
    input  logic rst_n,
    output lvl_t state
);
    localparam lvl_t ZERO = '0;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.state == ZERO) begin
            seq_d.state = SEED;
        end else begin
            seq_d.state = {seq_q.state[LVL_W-2:0], seq_feedback(seq_q.state, TAP_MASK)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEED;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.state;

    AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state != ZERO); // R2
    AST_SEQ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state != ZERO |=> seq_q.state != $past(seq_q.state)); // R3
endmodule

// File: rtl/lpwm_drive.sv
module lpwm_drive
    import lpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  lvl_t level,
    input  lvl_t seq_val,
    output logic drive
);
    drv_reg_t drv_d, drv_q;

    always_comb begin
        drv_d = drv_q;
        drv_d.drive = en && (seq_val < level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.drive <= 1'b0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign drive = drv_q.drive;

    AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !drv_q.drive); // R8
    AST_FLOOR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= lvl_t'(1)) |=> !drv_q.drive); // R5
endmodule

// File: rtl/lpwm_light.sv
module lpwm_light
    import lpwm_pkg::*;
#(
    parameter lvl_t TAP_MASK = 8'b1011_1000,
    parameter lvl_t SEED     = 8'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] level,
    output logic       light_out
);
    lvl_t seq_val;

    lpwm_seq #(.TAP_MASK(TAP_MASK), .SEED(SEED)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .state (seq_val)
    );

    lpwm_drive u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .level   (level),
        .seq_val (seq_val),
        .drive   (light_out)
    );

    AST_HIGH_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        light_out |-> ($past(level) >= 8'd2)); // R4
    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |-> !light_out); // R1
endmodule

// File: tb/sim_lpwm_light.sv
module sim_lpwm_light;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] level = 8'd0;
    logic       light_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit ref_pat [255];

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    lpwm_light u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .level     (level),
        .light_out (light_out)
    );

    function automatic int exp_highs(input int lv);
        return (lv < 2) ? 0 : lv - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_and_settle(input int lv);
        @(negedge clk);
        level = lv[7:0];
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic count_window(output int highs, output int lows);
        highs = 0;
        lows = 0;
        for (int i = 0; i < 255; i++) begin
            if (light_out) highs++; else lows++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int h, l, mism, lv;
        bit first [255];
        void'($urandom(32'h5EED_0042));

        // R1: dark during reset, seed 1 shows at level 2
        en = 1'b1;
        level = 8'd2;
        repeat (3) @(negedge clk);
        check(light_out == 1'b0, "R1 reset dark", light_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(light_out == 1'b1, "R1 first after reset", light_out, 1);
        @(negedge clk);
        check(light_out == 1'b0, "R1 second after reset", light_out, 0);

        // R5: floor levels
        set_and_settle(0);
        count_window(h, l);
        check(h == 0, "R5 level 0", h, 0);
        set_and_settle(1);
        count_window(h, l);
        check(h == 0, "R5 level 1", h, 0);

        // R6: single pulse
        set_and_settle(2);
        count_window(h, l);
        check(h == 1, "R6 level 2", h, 1);

        // R7: ceiling
        set_and_settle(255);
        count_window(h, l);
        check(h == 254, "R7 level 255 highs", h, 254);
        check(l >= 1, "R7 level 255 not solid", l, 1);

        // R4: random levels
        for (int k = 0; k < 12; k++) begin
            lv = int'($urandom_range(255, 0));
            set_and_settle(lv);
            count_window(h, l);
            check(h == exp_highs(lv), $sformatf("R4 level %0d", lv), h, exp_highs(lv));
        end
        set_and_settle(128);
        count_window(h, l);
        check(h == 127, "R4 level 128", h, 127);

        // R3: period 255
        set_and_settle(100);
        for (int i = 0; i < 255; i++) begin
            first[i] = light_out;
            @(negedge clk);
        end
        mism = 0;
        for (int i = 0; i < 255; i++) begin
            if (light_out != first[i]) mism++;
            @(negedge clk);
        end
        check(mism == 0, "R3 repeat after 255", mism, 0);

        // R9 reference at level 128
        set_and_settle(128);
        for (int i = 0; i < 255; i++) begin
            ref_pat[cyc % 255] = light_out;
            @(negedge clk);
        end

        // R8: disable forces dark
        en = 1'b0;
        level = 8'd255;
        @(negedge clk);
        mism = 0;
        for (int i = 0; i < 37; i++) begin
            if (light_out) mism++;
            @(negedge clk);
        end
        check(mism == 0, "R8 disabled dark", mism, 0);

        // R9: phase continues across disable gap
        level = 8'd128;
        en = 1'b1;
        repeat (2) @(negedge clk);
        mism = 0;
        for (int i = 0; i < 255; i++) begin
            if (light_out != ref_pat[cyc % 255]) mism++;
            @(negedge clk);
        end
        check(mism == 0, "R9 phase kept", mism, 0);

        // R8: one-clock latency on enable
        level = 8'd255;
        en = 1'b1;
        repeat (3) @(negedge clk);
        while (!light_out) @(negedge clk);
        en = 1'b0;
        check(light_out == 1'b1, "R8 latency hold", light_out, 1);
        @(negedge clk);
        check(light_out == 1'b0, "R8 latency dark", light_out, 0);

        finish_run();
    end
endmodule